// File: doc/BRIEF.md
# USB Suspend and Resume Controller

This block follows start-of-frame arrivals in a full-speed USB device and decides when the host has stopped all bus traffic. During normal operation a frame marker arrives every millisecond. A millisecond tick input advances a counter of missed frames, and each frame marker that arrives clears that counter. When three consecutive ticks pass with no frame marker, the block enters suspend. It then sets a sticky suspend status bit, and it raises an interrupt if the interrupt is enabled.

Once the device is in suspend, it can wake in two ways. Software can ask for a remote wakeup: the block then drives a resume request for a programmed number of ticks and afterwards waits for the host to finish the resume signalling. The host can also start the resume itself. In both cases the device returns to active operation only when the host signalling ends. A bus reset is honoured in every state, including suspend. It puts the block back into active operation, clears the miss counter and produces a reset-event pulse.

Top module: `usb_suspend_ctl`

## Requirements
- R1: While active, a tick with no frame marker in the same cycle increments the miss counter. A frame marker clears the counter to zero, and this includes a cycle in which a tick arrives alongside it.
- R2: The third consecutive tick without a frame marker makes `suspended` and `susp_flag` go high at the same clock edge. Two misses followed by a frame marker do not cause suspend.
- R3: `irq` is high exactly when `susp_flag` is high and `irq_en` is high.
- R4: A status write (`flag_wr_en`=1) with `flag_wr_data`=0 clears `susp_flag`. A write with data 1 leaves the flag unchanged. When suspend entry and a clearing write fall in the same cycle, the flag ends up set.
- R5: In suspend, `wake_req` raises `resume_drive` at the next edge. `resume_drive` then stays high until the edge of the N-th following tick, where N is `drive_len`, and a `drive_len` of 0 is treated as 1. `suspended` stays high while the resume is driven.
- R6: When the drive phase ends, the block stays suspended until `host_resume` has been seen high and then low. It becomes active at the edge where `host_resume` is sampled low.
- R7: In suspend, a high `host_resume` starts a host-led resume. The block becomes active at the edge where `host_resume` is sampled low again. If `host_resume` and `wake_req` are high in the same cycle, the host-led resume wins and no resume is driven.
- R8: A `bus_reset` in any state makes `suspended` and `resume_drive` low at the next edge. It clears the miss counter, so three further ticks are needed to suspend, and it pulses `reset_evt` high for exactly one cycle. A bus reset takes priority over a suspend entry in the same cycle.
- R9: While active, `wake_req` has no effect: `resume_drive` stays low.
- R10: While `rst_n` is low, `susp_flag`, `irq`, `suspended`, `resume_drive` and `reset_evt` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle strobe each millisecond |
| sof_rcvd | input | 1 | One-cycle strobe when a frame marker is received |
| bus_reset | input | 1 | One-cycle strobe when a bus reset is detected |
| host_resume | input | 1 | High while the host drives resume signalling |
| wake_req | input | 1 | Software request for remote wakeup |
| irq_en | input | 1 | Enable for the suspend interrupt |
| flag_wr_en | input | 1 | Software write strobe to the suspend status bit |
| flag_wr_data | input | 1 | Value written; 0 clears, 1 has no effect |
| drive_len | input | DRV_W | Remote-wakeup drive length in ticks |
| susp_flag | output | 1 | Sticky suspend status bit |
| irq | output | 1 | Suspend interrupt |
| suspended | output | 1 | Device is in suspend or in a resume that has not finished |
| resume_drive | output | 1 | Request to drive resume signalling on the bus |
| reset_evt | output | 1 | One-cycle pulse after a bus reset |

## Verification
Two pairs of functions can fall in the same cycle: the third missed tick together with a clearing write to the status bit, and the third missed tick together with a bus reset. The bench first counts two misses. It then puts the third tick in the same cycle as the write, and in a separate run in the same cycle as the bus reset. It judges the outcome at the following edge: the flag must stay set after the write collision. After the reset collision the block must not suspend, must pulse the reset event and must need three fresh misses to suspend. A host resume that coincides with a wakeup request is provoked in the same way.

// File: rtl/usb_susp_pkg.sv
package usb_susp_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_SUSP   = 2'd1,
    ST_DRIVE  = 2'd2,
    ST_WAIT   = 2'd3
  } susp_state_e;
endpackage

// File: rtl/sof_miss_cnt.sv
module sof_miss_cnt #(
  parameter int LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  input  logic ms_tick,
  input  logic sof,
  output logic limit_hit
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q, cnt_d;

  // last miss of the run: tick without a marker while the count sits one short
  assign limit_hit = en && !clr && ms_tick && !sof && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr || !en || sof) begin
      cnt_d = '0;
    end else if (ms_tick) begin
      if (cnt_q == LAST) cnt_d = '0;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wake_timer.sv
module wake_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  input  logic         run,
  output logic         done
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;

  assign done = run && (cnt_q == ONE);

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = (len == '0) ? ONE : len;
    end else if (run && cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/susp_fsm.sv
module susp_fsm
  import usb_susp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        limit_hit,
  input  logic        bus_reset,
  input  logic        host_resume,
  input  logic        wake_req,
  input  logic        timer_done,
  output susp_state_e state,
  output logic        timer_load,
  output logic        enter_susp
);
  susp_state_e st_q, st_d;
  logic        seen_q, seen_d;

  assign state      = st_q;
  assign enter_susp = (st_q == ST_ACTIVE) && limit_hit && !bus_reset;
  assign timer_load = (st_q == ST_SUSP) && wake_req && !host_resume && !bus_reset;

  always_comb begin
    st_d   = st_q;
    seen_d = seen_q;
    if (bus_reset) begin
      st_d   = ST_ACTIVE;
      seen_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_ACTIVE: if (limit_hit) st_d = ST_SUSP;
        ST_SUSP: begin
          if (host_resume) begin
            st_d   = ST_WAIT;
            seen_d = 1'b1;
          end else if (wake_req) begin
            st_d = ST_DRIVE;
          end
        end
        ST_DRIVE: begin
          if (timer_done) begin
            st_d   = ST_WAIT;
            seen_d = 1'b0;
          end
        end
        ST_WAIT: begin
          if (host_resume)  seen_d = 1'b1;
          else if (seen_q) begin
            st_d   = ST_ACTIVE;
            seen_d = 1'b0;
          end
        end
        default: st_d = ST_ACTIVE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_ACTIVE;
      seen_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      seen_q <= seen_d;
    end
  end
endmodule

// File: rtl/susp_status.sv
module susp_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_flag,
  input  logic wr_en,
  input  logic wr_data,
  input  logic bus_reset,
  output logic flag,
  output logic rst_pulse
);
  logic flag_d;

  // set has priority over a clearing write in the same cycle
  always_comb begin
    flag_d = flag;
    if (set_flag)                flag_d = 1'b1;
    else if (wr_en && !wr_data)  flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag      <= 1'b0;
      rst_pulse <= 1'b0;
    end else begin
      flag      <= flag_d;
      rst_pulse <= bus_reset;
    end
  end
endmodule

// File: rtl/usb_suspend_ctl.sv
module usb_suspend_ctl
  import usb_susp_pkg::*;
#(
  parameter int MISS_LIMIT = 3,
  parameter int DRV_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ms_tick,
  input  logic             sof_rcvd,
  input  logic             bus_reset,
  input  logic             host_resume,
  input  logic             wake_req,
  input  logic             irq_en,
  input  logic             flag_wr_en,
  input  logic             flag_wr_data,
  input  logic [DRV_W-1:0] drive_len,
  output logic             susp_flag,
  output logic             irq,
  output logic             suspended,
  output logic             resume_drive,
  output logic             reset_evt
);
  susp_state_e state;
  logic limit_hit, timer_load, timer_done, enter_susp;
  logic cnt_en, drive_run;

  assign cnt_en    = (state == ST_ACTIVE);
  assign drive_run = (state == ST_DRIVE) && ms_tick;

  sof_miss_cnt #(.LIMIT(MISS_LIMIT)) u_miss (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cnt_en),
    .clr       (bus_reset),
    .ms_tick   (ms_tick),
    .sof       (sof_rcvd),
    .limit_hit (limit_hit)
  );

  wake_timer #(.W(DRV_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (timer_load),
    .len   (drive_len),
    .run   (drive_run),
    .done  (timer_done)
  );

  susp_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .limit_hit   (limit_hit),
    .bus_reset   (bus_reset),
    .host_resume (host_resume),
    .wake_req    (wake_req),
    .timer_done  (timer_done),
    .state       (state),
    .timer_load  (timer_load),
    .enter_susp  (enter_susp)
  );

  susp_status u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_flag  (enter_susp),
    .wr_en     (flag_wr_en),
    .wr_data   (flag_wr_data),
    .bus_reset (bus_reset),
    .flag      (susp_flag),
    .rst_pulse (reset_evt)
  );

  assign suspended    = (state != ST_ACTIVE);
  assign resume_drive = (state == ST_DRIVE);
  assign irq          = susp_flag & irq_en;
endmodule

// File: rtl/usb_susp_chk.sv
module usb_susp_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_reset,
  input logic irq_en,
  input logic flag_wr_en,
  input logic flag_wr_data,
  input logic susp_flag,
  input logic irq,
  input logic suspended,
  input logic resume_drive,
  input logic reset_evt
);
  p_flag_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp_flag) |-> $rose(suspended));

  p_irq_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  p_irq_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_flag && irq_en) |-> irq);

  p_flag_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr_en && !flag_wr_data) |=> (!susp_flag || $rose(suspended)));

  p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_flag && !(flag_wr_en && !flag_wr_data)) |=> susp_flag);

  p_drive_in_susp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resume_drive |-> suspended);

  p_bus_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (!suspended && !resume_drive && reset_evt));

  p_evt_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_evt && !bus_reset) |=> !reset_evt);

  p_no_wake_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !suspended |=> !resume_drive);
endmodule

bind usb_suspend_ctl usb_susp_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_reset    (bus_reset),
  .irq_en       (irq_en),
  .flag_wr_en   (flag_wr_en),
  .flag_wr_data (flag_wr_data),
  .susp_flag    (susp_flag),
  .irq          (irq),
  .suspended    (suspended),
  .resume_drive (resume_drive),
  .reset_evt    (reset_evt)
);

// File: tb/sim_usb_suspend_ctl.sv
module sim_usb_suspend_ctl;
  logic clk = 1'b0;
  logic rst_n;
  logic ms_tick, sof_rcvd, bus_reset, host_resume, wake_req, irq_en;
  logic flag_wr_en, flag_wr_data;
  logic [3:0] drive_len;
  logic susp_flag, irq, suspended, resume_drive, reset_evt;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  usb_suspend_ctl u0 (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .sof_rcvd(sof_rcvd),
    .bus_reset(bus_reset), .host_resume(host_resume), .wake_req(wake_req),
    .irq_en(irq_en), .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data),
    .drive_len(drive_len), .susp_flag(susp_flag), .irq(irq),
    .suspended(suspended), .resume_drive(resume_drive), .reset_evt(reset_evt)
  );

  // vector: [16:13] requirement number, [12:5] inputs
  // tick sof brst hres wake we wd ien, [4:0] expected flag susp drv revt irq
  localparam int NV = 23;
  localparam logic [16:0] VT [NV] = '{
    {4'd1, 8'b1000_0001, 5'b00000},  // R1 miss 1
    {4'd1, 8'b1000_0001, 5'b00000},  // R1 miss 2
    {4'd1, 8'b0100_0001, 5'b00000},  // R1 marker clears
    {4'd1, 8'b1000_0001, 5'b00000},  // R1 miss 1
    {4'd1, 8'b1100_0001, 5'b00000},  // R1 tick with marker clears
    {4'd2, 8'b1000_0001, 5'b00000},  // R2 miss 1
    {4'd2, 8'b1000_0001, 5'b00000},  // R2 miss 2
    {4'd2, 8'b1000_0001, 5'b11001},  // R2 third miss suspends
    {4'd5, 8'b0000_1001, 5'b11101},  // R5 wake starts drive (len 2)
    {4'd5, 8'b1000_0001, 5'b11101},  // R5 first tick, still driving
    {4'd6, 8'b1000_0001, 5'b11001},  // R6 second tick ends drive
    {4'd6, 8'b0001_0001, 5'b11001},  // R6 host signalling seen
    {4'd6, 8'b0000_0001, 5'b10001},  // R6 host done, active
    {4'd4, 8'b0000_0111, 5'b10001},  // R4 write 1 no effect
    {4'd4, 8'b0000_0101, 5'b00000},  // R4 write 0 clears
    {4'd9, 8'b0000_1001, 5'b00000},  // R9 wake while active ignored
    {4'd3, 8'b1000_0000, 5'b00000},  // R3 miss 1, irq disabled
    {4'd3, 8'b1000_0000, 5'b00000},  // R3 miss 2
    {4'd3, 8'b1000_0000, 5'b11000},  // R3 flag set, irq masked
    {4'd7, 8'b0001_0000, 5'b11000},  // R7 host resume starts
    {4'd7, 8'b0000_0000, 5'b10000},  // R7 host done, active
    {4'd8, 8'b0010_0001, 5'b10011},  // R8 bus reset event
    {4'd8, 8'b0000_0001, 5'b10001}   // R8 event lasts one cycle
  };

  task automatic drive_in(input logic [7:0] v);
    {ms_tick, sof_rcvd, bus_reset, host_resume, wake_req,
     flag_wr_en, flag_wr_data, irq_en} = v;
  endtask

  // apply at negedge, let one edge pass, sample at the next negedge
  task automatic step(input logic [7:0] v);
    drive_in(v);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [4:0] exp);
    logic [4:0] act;
    act = {susp_flag, suspended, resume_drive, reset_evt, irq};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: flag/susp/drv/evt/irq actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    drive_in(8'b0);
    drive_len = 4'd2;
    repeat (3) @(negedge clk);
    check("R10 reset state", 5'b00000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VT[i][12:5]);
      check($sformatf("R%0d vector %0d", VT[i][16:13], i), VT[i][4:0]);
    end

    // R4: suspend entry and clearing write in the same cycle
    step(8'b0000_0101);
    check("R4 clear before collision", 5'b00000);
    step(8'b1000_0001);
    step(8'b1000_0001);
    step(8'b1000_0101);
    check("R4 set wins over clear", 5'b11001);

    // R8: reset from suspend
    step(8'b0010_0001);
    check("R8 reset leaves suspend", 5'b10011);

    // R8: bus reset in the cycle of the third miss
    step(8'b0000_0101);
    step(8'b1000_0001);
    step(8'b1000_0001);
    step(8'b1010_0001);
    check("R8 reset beats suspend entry", 5'b00010);
    step(8'b1000_0001);
    step(8'b1000_0001);
    check("R8 counter restarted", 5'b00000);
    step(8'b1000_0001);
    check("R8 three fresh misses suspend", 5'b11001);

    // R7: host resume and wake request together
    step(8'b0001_1001);
    check("R7 host wins over wake", 5'b11001);
    step(8'b0000_0001);
    check("R7 active after host ends", 5'b10001);

    // R5: drive length 0 treated as one tick
    step(8'b0000_0101);
    step(8'b1000_0001);
    step(8'b1000_0001);
    step(8'b1000_0001);
    drive_len = 4'd0;
    step(8'b0000_1001);
    check("R5 drive starts len0", 5'b11101);
    step(8'b1000_0001);
    check("R5 len0 ends after one tick", 5'b11001);
    step(8'b0000_0001);
    check("R6 no return without host signalling", 5'b11001);

    // R8: reset in the wait phase, then during a drive with a tick
    step(8'b0010_0001);
    check("R8 reset from wait", 5'b10011);
    drive_len = 4'd5;
    step(8'b1000_0001);
    step(8'b1000_0001);
    step(8'b1000_0001);
    step(8'b0000_1001);
    check("R5 drive len5 start", 5'b11101);
    step(8'b1000_0001);
    check("R5 drive continues", 5'b11101);
    step(8'b1010_0001);
    check("R8 reset stops drive", 5'b10011);

    // R10: reset mid-run
    drive_in(8'b0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 reset mid-run", 5'b00000);
    rst_n = 1'b1;
    step(8'b0000_0001);
    check("R10 idle after reset", 5'b00000);

    done = 1'b1;
    finish_run();
  end
endmodule